// File: doc/BRIEF.md
# Reset Vector Shadowing Controller

This block sits between an 8-bit processor with a 16-bit address bus and its boot ROM. When it sees a falling edge on the reset request line, it pulls the processor's reset line low. It keeps the processor in reset for a fixed, counted number of clock cycles, which extends the external pulse. During that hold the processor is off the bus, so the block takes the bus over. It puts its own addresses out, asserts the ROM chip select, and copies the sixteen vector bytes into internal registers. The bytes come from a remapped ROM window at internal offset 0x3FF0–0x3FFF, which the processor reaches at 0xBFF0–0xBFFF.

After the hold ends, a processor read of 0xFFF0–0xFFFF does not select the ROM. The block drives the stored byte for that address onto the data bus instead. Every other read passes through the normal ROM decode, which selects the ROM for 0x8000–0xFFFF. The address drivers and the data drivers are disabled at all other times. Each driver has an enable, so the pad logic can build the tristate bus. The block's own power-on reset starts the same hold sequence as a falling edge.

There is no data stream here. All pins are plain control and bus pins, with no valid/ready handshake and no back-pressure.

Top module: `vshadow_ctrl`

## Requirements
- R1: A falling edge on `rst_req_n` is detected when the signal is sampled low at a clock edge after it was sampled high at the edge before. From the next cycle, `rst_pull_o` is 1.
- R2: The hold lasts exactly HOLD_CYC cycles, counted from the restart. After that `rst_pull_o` returns to 0 with no further edge.
- R3: During the hold, byte i (0 to 15, in ascending order) is fetched over ACC_CYC consecutive cycles. Throughout those cycles `bus_addr_o` = 0xBFF0+i (ROM offset 0x3FF0+i on A0–A14), `bus_addr_oe_o` = 1 and `rom_cs_o` = 1.
- R4: Byte i is taken from `data_i` on the last cycle of its access. It is later returned for processor address 0xFFF0+i.
- R5: When the hold is over, a read (`cpu_rd_i`=1) of 0xFFF0–0xFFFF drives `rom_cs_o`=0 and `data_oe_o`=1. In the same cycle, `data_o` carries the stored byte selected by address bits 3:0.
- R6: When the hold is over, any other read gives `rom_cs_o` = 1 exactly when the address is at least 0x8000, with `data_oe_o` = 0.
- R7: A write (`cpu_rd_i`=0) to the vector area asserts neither `rom_cs_o` nor `data_oe_o`. It leaves the stored bytes unchanged.
- R8: A falling edge during the hold restarts the sequence from byte 0 and restarts the full hold count. No byte is captured in the cycle of the edge.
- R9: While `sys_rst_n` is low, the block is in the first cycle of a hold. It is pulling reset and fetching byte 0.
- R10: `bus_addr_oe_o` is 1 only while fetching. `data_oe_o` is 1 only for a vector reply and never together with `rom_cs_o`.
- R11: If `rst_req_n` stays low longer than the hold, the pull is still released after HOLD_CYC cycles. No new hold starts until a fresh falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| sys_rst_n | input | 1 | Block power-on reset, active low, asynchronous |
| rst_req_n | input | 1 | Sensed external reset request, active low |
| rst_pull_o | output | 1 | 1 = drive the processor reset line low |
| cpu_addr_i | input | 16 | Address driven by the processor |
| cpu_rd_i | input | 1 | Processor read strobe, 1 = read, 0 = write |
| data_i | input | 8 | Data bus as seen at the block (ROM output during fetch) |
| bus_addr_o | output | 16 | Address the block drives during a fetch |
| bus_addr_oe_o | output | 1 | Enable for the block's address drivers |
| data_o | output | 8 | Stored vector byte for a reply |
| data_oe_o | output | 1 | Enable for the block's data drivers |
| rom_cs_o | output | 1 | ROM chip select, active high |

## Verification
The hardest case to reach is a second falling edge that lands partway through the fetch. At that point some vector registers already hold new bytes and some still hold old ones. Only a later vector read can show whether every slot was fetched again. To reach this case, the bench changes the ROM image between the two edges. It fires the second edge twelve cycles into the hold and then reads all sixteen vectors, each of which must match the newest image. A reset request held low past the end of the hold is also driven, to show that the release does not wait for the line to rise.

// File: rtl/vsh_pkg.sv
`timescale 1ns/1ps
package vsh_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/vsh_edge.sv
`timescale 1ns/1ps
// Falling-edge detector on the sensed reset request line.
module vsh_edge (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic line_n,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) prev_q <= 1'b1;
    else            prev_q <= line_n;
  end

  assign fall_o = prev_q & ~line_n;
endmodule

// File: rtl/vsh_seq.sv
`timescale 1ns/1ps
// Hold counter and vector fetch sequencer.
module vsh_seq
  import vsh_pkg::*;
#(
  parameter int    HOLD_CYC   = 48,
  parameter int    ACC_CYC    = 2,
  parameter int    VEC_N      = 16,
  parameter addr_t FETCH_BASE = 16'hBFF0
) (
  input  logic                     clk,
  input  logic                     sys_rst_n,
  input  logic                     fall_i,
  output logic                     hold_o,
  output logic                     fetch_o,
  output addr_t                    fetch_addr_o,
  output logic                     cap_en_o,
  output logic [$clog2(VEC_N)-1:0] cap_idx_o
);
  localparam int HC_W = $clog2(HOLD_CYC + 1);
  localparam int SB_W = $clog2(ACC_CYC + 1);
  localparam int IX_W = $clog2(VEC_N);

  logic            hold_q, done_q;
  logic [HC_W-1:0] hcnt_q;
  logic [SB_W-1:0] sub_q;
  logic [IX_W-1:0] idx_q;
  logic            last_sub, last_idx, last_hold;

  assign last_sub  = (sub_q  == SB_W'(ACC_CYC - 1));
  assign last_idx  = (idx_q  == IX_W'(VEC_N - 1));
  assign last_hold = (hcnt_q == HC_W'(HOLD_CYC - 1));

  assign hold_o       = hold_q;
  assign fetch_o      = hold_q & ~done_q;
  assign fetch_addr_o = FETCH_BASE + addr_t'(idx_q);
  assign cap_en_o     = fetch_o & last_sub & ~fall_i;
  assign cap_idx_o    = idx_q;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      hold_q <= 1'b1;
      done_q <= 1'b0;
      hcnt_q <= '0;
      sub_q  <= '0;
      idx_q  <= '0;
    end else if (fall_i) begin
      hold_q <= 1'b1;
      done_q <= 1'b0;
      hcnt_q <= '0;
      sub_q  <= '0;
      idx_q  <= '0;
    end else if (hold_q) begin
      if (last_hold) begin
        hold_q <= 1'b0;
        hcnt_q <= '0;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
      if (fetch_o) begin
        if (last_sub) begin
          sub_q <= '0;
          if (last_idx) done_q <= 1'b1;
          else          idx_q  <= idx_q + 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  // R3: each completed access moves to the next vector slot
  p_idx_advance_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (fetch_o && last_sub && !last_idx && !fall_i) |=> (idx_q == $past(idx_q) + 1'b1));

  // R8: an edge restarts from byte 0 and a fresh count
  p_restart_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    fall_i |=> (hold_q && !done_q && idx_q == '0 && hcnt_q == '0));

  // R2: the hold ends at its last counted cycle
  p_release_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (hold_q && last_hold && !fall_i) |=> !hold_o);

  // R4: all bytes are fetched before the processor is let go
  p_fetched_before_release_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (hold_q && last_hold) |-> done_q);
endmodule

// File: rtl/vsh_vstore.sv
`timescale 1ns/1ps
// Shadow registers for the vector bytes.
module vsh_vstore
  import vsh_pkg::*;
#(
  parameter int VEC_N = 16
) (
  input  logic                     clk,
  input  logic                     sys_rst_n,
  input  logic                     cap_en_i,
  input  logic [$clog2(VEC_N)-1:0] cap_idx_i,
  input  byte_t                    cap_data_i,
  input  logic [$clog2(VEC_N)-1:0] rd_idx_i,
  output byte_t                    rd_data_o
);
  localparam int IX_W = $clog2(VEC_N);

  logic [VEC_N-1:0]             wen;
  logic [VEC_N-1:0][DATA_W-1:0] vec_q;

  for (genvar g = 0; g < VEC_N; g++) begin : g_slot_we
    assign wen[g] = cap_en_i && (cap_idx_i == IX_W'(g));
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      vec_q <= '0;
    end else begin
      for (int k = 0; k < VEC_N; k++) begin
        if (wen[k]) vec_q[k] <= cap_data_i;
      end
    end
  end

  assign rd_data_o = vec_q[rd_idx_i];

  // R7: nothing but a fetch capture alters the shadow bytes
  p_store_stable_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !cap_en_i |=> $stable(vec_q));
endmodule

// File: rtl/vsh_busmux.sv
`timescale 1ns/1ps
// Bus steering: fetch drive, vector reply and pass-through ROM decode.
module vsh_busmux
  import vsh_pkg::*;
#(
  parameter int    VEC_N    = 16,
  parameter addr_t VEC_BASE = 16'hFFF0,
  parameter addr_t ROM_LO   = 16'h8000
) (
  input  logic                     hold_i,
  input  logic                     fetch_i,
  input  addr_t                    fetch_addr_i,
  input  addr_t                    cpu_addr_i,
  input  logic                     cpu_rd_i,
  input  byte_t                    vec_data_i,
  output logic [$clog2(VEC_N)-1:0] vec_idx_o,
  output addr_t                    bus_addr_o,
  output logic                     bus_addr_oe_o,
  output byte_t                    data_o,
  output logic                     data_oe_o,
  output logic                     rom_cs_o
);
  localparam int    IX_W     = $clog2(VEC_N);
  localparam addr_t VEC_MASK = ~addr_t'(VEC_N - 1);

  logic in_vec, in_rom, reply;

  assign in_vec = ((cpu_addr_i & VEC_MASK) == VEC_BASE);
  assign in_rom = (cpu_addr_i >= ROM_LO);
  assign reply  = ~hold_i & cpu_rd_i & in_vec;

  assign vec_idx_o     = cpu_addr_i[IX_W-1:0];
  assign bus_addr_oe_o = fetch_i;
  assign bus_addr_o    = fetch_i ? fetch_addr_i : '0;
  assign data_oe_o     = reply;
  assign data_o        = reply ? vec_data_i : '0;
  assign rom_cs_o      = fetch_i | (~hold_i & cpu_rd_i & in_rom & ~in_vec);
endmodule

// File: rtl/vshadow_ctrl.sv
`timescale 1ns/1ps
// Top: reset hold, vector shadow fetch and vector reply.
module vshadow_ctrl
  import vsh_pkg::*;
#(
  parameter int    HOLD_CYC   = 48,
  parameter int    ACC_CYC    = 2,
  parameter int    VEC_N      = 16,
  parameter addr_t FETCH_BASE = 16'hBFF0,
  parameter addr_t VEC_BASE   = 16'hFFF0,
  parameter addr_t ROM_LO     = 16'h8000
) (
  input  logic        clk,
  input  logic        sys_rst_n,
  input  logic        rst_req_n,
  output logic        rst_pull_o,
  input  logic [15:0] cpu_addr_i,
  input  logic        cpu_rd_i,
  input  logic [7:0]  data_i,
  output logic [15:0] bus_addr_o,
  output logic        bus_addr_oe_o,
  output logic [7:0]  data_o,
  output logic        data_oe_o,
  output logic        rom_cs_o
);
  localparam int IX_W      = $clog2(VEC_N);
  localparam int FETCH_CYC = VEC_N * ACC_CYC;

  initial begin
    assert (ACC_CYC >= 2 && HOLD_CYC >= FETCH_CYC)
      else $error("hold too short for the vector fetch");
  end

  logic            fall, hold, fetch, cap_en;
  addr_t           fetch_addr;
  logic [IX_W-1:0] cap_idx, vec_idx;
  byte_t           vec_data;

  vsh_edge u_edge (
    .clk(clk), .sys_rst_n(sys_rst_n), .line_n(rst_req_n), .fall_o(fall)
  );

  vsh_seq #(
    .HOLD_CYC(HOLD_CYC), .ACC_CYC(ACC_CYC), .VEC_N(VEC_N), .FETCH_BASE(FETCH_BASE)
  ) u_seq (
    .clk(clk), .sys_rst_n(sys_rst_n), .fall_i(fall), .hold_o(hold),
    .fetch_o(fetch), .fetch_addr_o(fetch_addr), .cap_en_o(cap_en), .cap_idx_o(cap_idx)
  );

  vsh_vstore #(.VEC_N(VEC_N)) u_store (
    .clk(clk), .sys_rst_n(sys_rst_n), .cap_en_i(cap_en), .cap_idx_i(cap_idx),
    .cap_data_i(data_i), .rd_idx_i(vec_idx), .rd_data_o(vec_data)
  );

  vsh_busmux #(.VEC_N(VEC_N), .VEC_BASE(VEC_BASE), .ROM_LO(ROM_LO)) u_mux (
    .hold_i(hold), .fetch_i(fetch), .fetch_addr_i(fetch_addr),
    .cpu_addr_i(cpu_addr_i), .cpu_rd_i(cpu_rd_i), .vec_data_i(vec_data),
    .vec_idx_o(vec_idx), .bus_addr_o(bus_addr_o), .bus_addr_oe_o(bus_addr_oe_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .rom_cs_o(rom_cs_o)
  );

  assign rst_pull_o = hold;

  // R1: a detected edge pulls reset in the following cycle
  p_pull_after_fall_r1: assert property (@(posedge clk) disable iff (!sys_rst_n)
    fall |=> rst_pull_o);

  // R10: address drive only while the processor is held
  p_addr_in_hold_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    bus_addr_oe_o |-> rst_pull_o);

  // R5: a vector reply never also selects the ROM
  p_reply_no_rom_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    data_oe_o |-> (!rom_cs_o && !rst_pull_o));

  // R7: a write after the hold neither selects the ROM nor drives data
  p_write_quiet_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!cpu_rd_i && !rst_pull_o) |-> (!rom_cs_o && !data_oe_o));
endmodule

// File: tb/vshadow_ctrl_test.sv
`timescale 1ns/1ps
module vshadow_ctrl_test;
  localparam int CLK_P = 10;
  localparam int HOLD  = 48;
  localparam int ACC   = 2;
  localparam int NV    = 16;

  logic        clk = 1'b0;
  logic        sys_rst_n, rst_req_n, cpu_rd;
  logic [15:0] cpu_addr;
  logic [7:0]  data_in;
  logic        rst_pull, addr_oe, data_oe, rom_cs;
  logic [15:0] bus_addr_out, bus_addr;
  logic [7:0]  data_out;
  int          seed;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  bit  m_hold, m_prev;
  int  m_cyc;
  int  m_vec [NV];

  always #(CLK_P/2) clk = ~clk;

  vshadow_ctrl #(.HOLD_CYC(HOLD), .ACC_CYC(ACC), .VEC_N(NV)) uut (
    .clk(clk), .sys_rst_n(sys_rst_n), .rst_req_n(rst_req_n), .rst_pull_o(rst_pull),
    .cpu_addr_i(cpu_addr), .cpu_rd_i(cpu_rd), .data_i(data_in),
    .bus_addr_o(bus_addr_out), .bus_addr_oe_o(addr_oe),
    .data_o(data_out), .data_oe_o(data_oe), .rom_cs_o(rom_cs)
  );

  function automatic int rom_rd(int off, int sd);
    return ((off & 255) * 7 + ((off >> 8) & 127) + sd) & 255;
  endfunction

  // ROM model on the shared bus
  assign bus_addr = addr_oe ? bus_addr_out : cpu_addr;
  always_comb data_in = rom_cs ? 8'(rom_rd(int'(bus_addr[14:0]), seed)) : 8'h00;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit fetching, in_vec, reply, cs_exp;
    fetching = m_hold && (m_cyc < NV*ACC);
    in_vec   = (cpu_addr >= 16'hFFF0);
    reply    = !m_hold && cpu_rd && in_vec;
    cs_exp   = fetching || (!m_hold && cpu_rd && cpu_addr >= 16'h8000 && !in_vec);
    chk("R2", "rst_pull", int'(rst_pull), int'(m_hold));
    chk("R10", "addr_oe", int'(addr_oe), int'(fetching));
    if (fetching) chk("R3", "fetch addr", int'(bus_addr_out), 16'hBFF0 + m_cyc/ACC);
    chk("R6", "rom_cs", int'(rom_cs), int'(cs_exp));
    chk("R10", "data_oe", int'(data_oe), int'(reply));
    if (reply) chk("R5", "reply data", int'(data_out), m_vec[cpu_addr & 15]);
  endtask

  task automatic model_update();
    bit fall;
    if (!sys_rst_n) begin
      m_hold = 1; m_cyc = 0; m_prev = 1;
      return;
    end
    fall = m_prev && !rst_req_n;
    m_prev = rst_req_n;
    if (fall) begin
      m_hold = 1; m_cyc = 0;
    end else if (m_hold) begin
      if (m_cyc < NV*ACC && (m_cyc % ACC) == ACC-1)
        m_vec[m_cyc/ACC] = rom_rd(16'h3FF0 + m_cyc/ACC, seed);
      if (m_cyc == HOLD-1) m_hold = 0;
      else m_cyc++;
    end
  endtask

  task automatic tick();
    #1;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // read all vectors and compare with the ROM window for a given image (R4)
  task automatic read_vectors(int sd);
    for (int i = 0; i < NV; i++) begin
      cpu_addr = 16'hFFF0 + 16'(i);
      cpu_rd   = 1'b1;
      #1;
      chk("R4", "vector byte", int'(data_out), rom_rd(16'h3FF0 + i, sd));
      chk("R5", "rom_cs on vector read", int'(rom_cs), 0);
      tick();
    end
    cpu_rd = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) m_vec[i] = 0;
    m_hold = 1; m_prev = 1; m_cyc = 0;
    sys_rst_n = 1'b0; rst_req_n = 1'b1; cpu_rd = 1'b0; cpu_addr = 16'h0000; seed = 3;
    @(negedge clk);
    #1;
    chk("R9", "pull in reset", int'(rst_pull), 1);
    chk("R9", "fetch addr in reset", int'(bus_addr_out), 16'hBFF0);
    chk("R9", "cs in reset", int'(rom_cs), 1);
    ticks(2);
    sys_rst_n = 1'b1;
    ticks(HOLD + 2);
    chk("R2", "released after power-on hold", int'(rst_pull), 0);
    read_vectors(3);

    // pass-through reads (R6)
    cpu_rd = 1'b1;
    cpu_addr = 16'h7FFF; tick();
    cpu_addr = 16'h8000; #1; chk("R6", "cs at 8000", int'(rom_cs), 1); tick();
    cpu_addr = 16'hBFF5; tick();
    cpu_addr = 16'hFFEF; #1; chk("R6", "cs at FFEF", int'(rom_cs), 1); tick();
    cpu_addr = 16'h1234; #1; chk("R6", "no cs at 1234", int'(rom_cs), 0); tick();

    // write to vector area is ignored (R7)
    cpu_rd = 1'b0; cpu_addr = 16'hFFF3;
    #1;
    chk("R7", "write cs", int'(rom_cs), 0);
    chk("R7", "write data_oe", int'(data_oe), 0);
    tick();
    cpu_rd = 1'b1; #1;
    chk("R7", "vector after write", int'(data_out), rom_rd(16'h3FF3, 3));
    tick();
    cpu_rd = 1'b0;

    // external pulse in run with a new ROM image (R1)
    seed = 11;
    rst_req_n = 1'b0;
    tick();
    chk("R1", "pull after edge", int'(rst_pull), 1);
    ticks(2);
    rst_req_n = 1'b1;
    ticks(HOLD + 2);
    read_vectors(11);

    // second edge partway through the fetch (R8)
    seed = 20;
    rst_req_n = 1'b0; tick(); rst_req_n = 1'b1;
    ticks(12);
    seed = 33;
    rst_req_n = 1'b0; tick(); rst_req_n = 1'b1;
    chk("R8", "restart addr", int'(bus_addr_out), 16'hBFF0);
    ticks(HOLD - 4);
    chk("R8", "still held after restart", int'(rst_pull), 1);
    ticks(6);
    read_vectors(33);

    // request held low past the hold (R11)
    seed = 40;
    rst_req_n = 1'b0;
    ticks(HOLD + 10);
    chk("R11", "released while request low", int'(rst_pull), 0);
    rst_req_n = 1'b1;
    ticks(4);
    chk("R11", "no new hold on rise", int'(rst_pull), 0);
    read_vectors(40);

    summary();
    $finish;
  end
endmodule